// File: doc/BRIEF.md
# Addressed Interrupting Measurement Receiver

This peripheral samples a 32-bit two's complement measurement from its source input at a fixed interval, holds it, and raises an interrupt request to announce that a fresh value is available. The request is served by an acknowledge line that is passed from device to device. When this device has a request pending, it takes the acknowledge for itself, lowers its request and, one cycle later, places its identifier on the shared data lines. When it has nothing pending, it forwards the acknowledge to the next device.

Independently of interrupts, the processor can read the held measurement by placing this device's address on the device address bus. One cycle later the device drives the measurement onto the shared data lines. An acknowledge that this device accepts takes precedence over an address match in the same cycle. Address zero is reserved for identifier cycles and never selects the device. Upstream devices in the acknowledge chain, such as a timer, are served before this one.

Outputs are registered, except for the forwarded acknowledge, which must pass through in the same cycle. When nothing is driven, the data output is zero, so the shared lines can be merged with an OR.

Top module: `meas_rx_dev`

## Requirements
- R1: While reset is high and in the cycle after it, int_o is 0, data_oe is 0 and data_o is 0.
- R2: Counting rising edges with reset low from 1, int_o becomes 1 after every edge whose number is a multiple of PERIOD, and stays 1 until the request is acknowledged.
- R3: At each such capture edge, the value on meas_i is latched as a signed word and held unchanged until the next capture edge.
- R4: If ack_in is 1 at an edge while int_o is 1, and that edge is not a capture edge, int_o is 0 after that edge.
- R5: After an edge at which ack_in and int_o are both 1, data_oe is 1 and data_o equals DEV_ID for exactly that one cycle, unless another drive follows.
- R6: ack_out equals ack_in in the same cycle when int_o is 0, and is 0 when int_o is 1.
- R7: After an edge at which addr_i equals DEV_ADDR (nonzero) and no acknowledge is taken, data_oe is 1 and data_o equals the measurement held before that edge.
- R8: An addr_i value of zero, or any value other than DEV_ADDR, drives nothing unless an acknowledge is taken.
- R9: When an acknowledge is taken and addr_i matches at the same edge, the identifier is driven and the measurement is not.
- R10: When an acknowledge is taken at a capture edge, int_o stays 1 for the new capture, and the identifier is still driven in the next cycle.
- R11: Whenever data_oe is 0, data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_o | output | 1 | Interrupt request, registered |
| ack_in | input | 1 | Acknowledge arriving from upstream in the chain |
| ack_out | output | 1 | Acknowledge forwarded downstream when nothing is pending |
| addr_i | input | ADDR_W (20) | Device address bus |
| meas_i | input | DATA_W (32) | Measurement source |
| data_o | output | DATA_W (32) | Data toward the shared bus, zero when idle |
| data_oe | output | 1 | Drive enable for data_o |

## Verification
The bench builds the block with PERIOD set to 12 and ADDR_W set to 4, leaving DEV_ID and DEV_ADDR at 1. The short interval brings around twenty capture edges into a short run. The narrow address bus lets every address value, zero included, be presented many times against a cycle model computed in the bench. One phase places acknowledges exactly on capture edges with the address held at the device's own value, which reaches both the precedence rule and the case of a new request arriving together with an acknowledge.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_ID   = 2'd1,
    SRC_MEAS = 2'd2
  } drv_src_e;

  function automatic drv_src_e pick_src(input logic id_req, input logic addr_req);
    if (id_req)        return SRC_ID;
    else if (addr_req) return SRC_MEAS;
    else               return SRC_IDLE;
  endfunction
endpackage

// File: rtl/mrx_tick.sv
module mrx_tick #(
  parameter int PERIOD = 2500
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mrx_irq.sv
module mrx_irq (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ack_in,
  output logic pend,
  output logic ack_hit,
  output logic ack_out
);
  assign ack_hit = ack_in & pend;
  assign ack_out = ack_in & ~pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= tick | (pend & ~ack_in);
  end
endmodule

// File: rtl/mrx_sample.sv
module mrx_sample #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] meas_i,
  output logic [DATA_W-1:0] meas_q
);
  always_ff @(posedge clk) begin
    if (rst)       meas_q <= '0;
    else if (tick) meas_q <= meas_i;
  end
endmodule

// File: rtl/mrx_drive.sv
module mrx_drive
  import mrx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 20,
  parameter int DEV_ID   = 1,
  parameter int DEV_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_hit,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] meas_q,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);
  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'(DEV_ID);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);

  logic     addr_hit;
  drv_src_e src;

  generate
    if (DEV_ADDR == 0) begin : g_no_addr
      assign addr_hit = 1'b0;
    end else begin : g_addr
      assign addr_hit = (addr_i == MY_ADDR);
    end
  endgenerate

  assign src = pick_src(ack_hit, addr_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      data_oe <= 1'b0;
    end else begin
      unique case (src)
        SRC_ID: begin
          data_o  <= ID_WORD;
          data_oe <= 1'b1;
        end
        SRC_MEAS: begin
          data_o  <= meas_q;
          data_oe <= 1'b1;
        end
        default: begin
          data_o  <= '0;
          data_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/meas_rx_dev.sv
module meas_rx_dev #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 20,
  parameter int DEV_ID   = 1,
  parameter int DEV_ADDR = 1,
  parameter int PERIOD   = 2500
) (
  input  logic              clk,
  input  logic              rst,
  output logic              int_o,
  input  logic              ack_in,
  output logic              ack_out,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] meas_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);
  logic              tick_w;
  logic              pend_w;
  logic              ack_hit_w;
  logic [DATA_W-1:0] meas_q;

  mrx_tick #(.PERIOD(PERIOD)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  mrx_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_w),
    .ack_in (ack_in),
    .pend   (pend_w),
    .ack_hit(ack_hit_w),
    .ack_out(ack_out)
  );

  mrx_sample #(.DATA_W(DATA_W)) u_sample (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_w),
    .meas_i(meas_i),
    .meas_q(meas_q)
  );

  mrx_drive #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .DEV_ID  (DEV_ID),
    .DEV_ADDR(DEV_ADDR)
  ) u_drive (
    .clk    (clk),
    .rst    (rst),
    .ack_hit(ack_hit_w),
    .addr_i (addr_i),
    .meas_q (meas_q),
    .data_o (data_o),
    .data_oe(data_oe)
  );

  assign int_o = pend_w;
endmodule

// File: rtl/mrx_check.sv
module mrx_check #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 20,
  parameter int DEV_ID   = 1,
  parameter int DEV_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              int_o,
  input logic              ack_in,
  input logic              ack_out,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe,
  input logic              tick,
  input logic [DATA_W-1:0] meas_q
);
  a_r2_request_on_capture: assert property (@(posedge clk) disable iff (rst)
    tick |=> int_o);

  a_r3_measure_held: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(meas_q));

  a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (int_o && ack_in && !tick) |=> !int_o);

  a_r5_id_after_ack: assert property (@(posedge clk) disable iff (rst)
    (int_o && ack_in) |=> (data_oe && data_o == DATA_W'(DEV_ID)));

  a_r6_block_when_pending: assert property (@(posedge clk) disable iff (rst)
    int_o |-> !ack_out);

  a_r6_forward_when_idle: assert property (@(posedge clk) disable iff (rst)
    !int_o |-> (ack_out == ack_in));

  a_r7_addr_read: assert property (@(posedge clk) disable iff (rst)
    (DEV_ADDR != 0 && addr_i == ADDR_W'(DEV_ADDR) && !(int_o && ack_in))
      |=> (data_oe && data_o == $past(meas_q)));

  a_r8_zero_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    (addr_i == '0 && !(int_o && ack_in)) |=> !data_oe);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_o == '0));
endmodule

bind meas_rx_dev mrx_check #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .DEV_ID  (DEV_ID),
  .DEV_ADDR(DEV_ADDR)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .int_o  (int_o),
  .ack_in (ack_in),
  .ack_out(ack_out),
  .addr_i (addr_i),
  .data_o (data_o),
  .data_oe(data_oe),
  .tick   (tick_w),
  .meas_q (meas_q)
);

// File: tb/sim_meas_rx_dev.sv
`timescale 1ns/1ps
module sim_meas_rx_dev;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int P  = 12;
  localparam int ID = 1;
  localparam int DA = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ack_in = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] meas_i = '0;
  logic          int_o, ack_out, data_oe;
  logic [DW-1:0] data_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench-side expectation state
  int            e = 0;
  logic          m_pend = 1'b0;
  logic [DW-1:0] m_meas = '0;
  logic          x_oe = 1'b0;
  logic [DW-1:0] x_data = '0;
  string         x_tag = "R1";

  always #10 clk = ~clk;

  meas_rx_dev #(
    .DATA_W(DW), .ADDR_W(AW), .DEV_ID(ID), .DEV_ADDR(DA), .PERIOD(P)
  ) u0 (
    .clk(clk), .rst(rst), .int_o(int_o), .ack_in(ack_in), .ack_out(ack_out),
    .addr_i(addr_i), .meas_i(meas_i), .data_o(data_o), .data_oe(data_oe)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %h expected %h", req, e, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gen(input int k);
    return (DW'(k) * 32'h9E37_79B1) ^ 32'h8000_0003;
  endfunction

  // one cycle: drive at negedge, check pass-through, take the edge, check at next negedge
  task automatic cyc(input logic ack, input logic [AW-1:0] addr);
    logic tick, hit, amatch;
    ack_in = ack;
    addr_i = addr;
    meas_i = gen(e + 1);
    #1;
    chk("R6", {31'b0, ack_out}, {31'b0, ack & ~m_pend});
    @(posedge clk);
    e++;
    tick   = (e % P) == 0;
    hit    = ack & m_pend;
    amatch = (addr == AW'(DA)) && (addr != '0);
    if (hit) begin
      x_oe = 1'b1; x_data = DW'(ID);
      x_tag = amatch ? "R9" : (tick ? "R10" : "R5");
    end else if (amatch) begin
      x_oe = 1'b1; x_data = m_meas; x_tag = "R7 R3";
    end else begin
      x_oe = 1'b0; x_data = '0; x_tag = "R8 R11";
    end
    m_pend = tick | (m_pend & ~ack);
    if (tick) m_meas = meas_i;
    @(negedge clk);
    chk((tick && hit) ? "R10" : "R2 R4", {31'b0, int_o}, {31'b0, m_pend});
    chk(x_tag, {31'b0, data_oe}, {31'b0, x_oe});
    chk(x_tag, data_o, x_data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", {31'b0, int_o}, 32'd0);
    chk("R1", {31'b0, data_oe}, 32'd0);
    chk("R1", data_o, 32'd0);
    rst = 1'b0;
    // phase A: full address sweep, irregular acknowledges
    for (int i = 0; i < 160; i++)
      cyc(((e + 1) % 5 == 2) || ((e + 1) % 7 == 0), AW'(e + 1));
    // phase B: acknowledge exactly on capture edges with own address (R9, R10)
    for (int i = 0; i < 60; i++)
      cyc(((e + 1) % P) == 0, AW'(DA));
    // phase C: no acknowledge, request stays up, sweep including zero (R8)
    for (int i = 0; i < 48; i++)
      cyc(1'b0, AW'(i));
    // phase D: acknowledge held high constantly, address zero
    for (int i = 0; i < 30; i++)
      cyc(1'b1, '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule